// File: doc/BRIEF.md
# Elimination Lattice Propagator

This block is a clocked model of a network of row nets and column nets used to test a sparse Boolean equation system for consistency. Each row net stands for one candidate solution vector of one equation. Each pairing of two equations on a shared projection value contributes two column nets. A column reads a group of rows through series (AND) contacts and, once powered, feeds a second group of rows through parallel (OR) contacts. A powered row means that its candidate vector cannot be part of any common solution.

The wiring of the lattice is fixed when the design is elaborated. It is given by packed parameter masks that list, for each column, the rows it reads and the rows it drives, for each guess line the rows it powers, and for each equation the rows that belong to it. Between trials a synchronous clear removes power from every net. Guess lines then inject power, and each clock edge performs one simultaneous switch turn. Power spreads until nothing changes any more. If every row of any one equation ends up powered, the system is inconsistent under that guess.

Top module: `elim_lattice`

## Requirements
- R1: While `rstN` is low, every row and column net is off, and `settled`, `inconsistent` and all `eqDead` bits are low on the cycle after reset is applied.
- R2: An edge with `clearIn` high turns every net off and drops `settled`. The `guessIn` value present on that edge has no effect, so `rowLive` reads all zero after it.
- R3: On an edge with `clearIn` low, a row turns on if any column that drives it was on before the edge, or if any guess line wired to it is high.
- R4: On an edge with `clearIn` low, a column turns on if every row in its series list was on before the edge. A column with an empty series list turns on at the first such edge after a clear or reset, with no guess applied.
- R5: Between clears, no row or column ever turns off.
- R6: `eqDead[e]` is high exactly when every row belonging to equation e is on in `rowLive`.
- R7: `inconsistent` is high exactly when at least one `eqDead` bit is high.
- R8: `settled` goes high after an edge (with `clearIn` low) at which no net changed, and is low after any edge at which a net turned on.
- R9: With the guess held steady after a clear, `settled` is high no later than NUM_ROWS+NUM_COLS+1 edges after the clear.
- R10: With the default three-equation wiring (8 rows, 14 columns, guess line 0 powering row 3 and guess line 1 powering row 4), either guess line alone ends with all eight rows on and `inconsistent` high. `inconsistent` first rises 5 edges after the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each edge is one switch turn |
| rstN | input | 1 | Active-low synchronous reset |
| clearIn | input | 1 | Synchronous clear of all nets before a new guess |
| guessIn | input | NUM_GUESS | Guess lines; each powers its wired rows |
| rowLive | output | NUM_ROWS | Powered state of each row net |
| eqDead | output | NUM_EQ | Per equation: all candidate rows eliminated |
| inconsistent | output | 1 | Some equation has lost every candidate |
| settled | output | 1 | No net changed on the last propagation edge |

## Verification
The bench builds two instances. The first uses the default parameters: three equations with 3, 2 and 3 candidates, seven pairings (14 columns), and two guess lines on the shared variable. The second uses a three-row, two-column wiring with a column whose series list is empty, which brings the no-guess seeding path and a partly eliminated system within reach. For both wirings, every guess pattern is swept. An arithmetic propagation model in the bench predicts every net edge by edge, and the default wiring's hand-derived end state and first-inconsistency edge are checked explicitly.

// File: rtl/elim_lattice_pkg.sv
package elim_lattice_pkg;

  // Strobes from control to the datapath for one switch turn.
  typedef struct packed {
    logic clearNets;  // de-energize every net on this edge
    logic advance;    // perform one propagation step on this edge
  } latticeStrobes_t;

endpackage

// File: rtl/elim_lattice_ctrl.sv
module elim_lattice_ctrl
  import elim_lattice_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            clearIn,
  input  logic            netsChanged,
  output latticeStrobes_t strobes,
  output logic            settled
);

  always_comb begin
    strobes.clearNets = clearIn;
    strobes.advance   = !clearIn;
  end

  // A propagation step with no change means the fixpoint is reached.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      settled <= 1'b0;
    end else if (strobes.clearNets) begin
      settled <= 1'b0;
    end else begin
      settled <= !netsChanged;
    end
  end

endmodule

// File: rtl/elim_lattice_datapath.sv
module elim_lattice_datapath
  import elim_lattice_pkg::*;
#(
  parameter int NUM_ROWS  = 8,
  parameter int NUM_COLS  = 14,
  parameter int NUM_GUESS = 2,
  parameter logic [NUM_COLS*NUM_ROWS-1:0]  COL_IN_MASK  = '0,
  parameter logic [NUM_COLS*NUM_ROWS-1:0]  COL_OUT_MASK = '0,
  parameter logic [NUM_GUESS*NUM_ROWS-1:0] GUESS_MASK   = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  latticeStrobes_t      strobes,
  input  logic [NUM_GUESS-1:0] guessIn,
  output logic [NUM_ROWS-1:0]  rowState,
  output logic                 netsChanged
);

  logic [NUM_COLS-1:0] colState;
  logic [NUM_COLS-1:0] colFire;
  logic [NUM_ROWS-1:0] rowFire;
  logic [NUM_ROWS-1:0] rowNext;
  logic [NUM_COLS-1:0] colNext;

  // Column nets: series contacts, all listed rows must be energized.
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    localparam logic [NUM_ROWS-1:0] SERIES = COL_IN_MASK[c*NUM_ROWS +: NUM_ROWS];
    assign colFire[c] = &(rowState | ~SERIES);
  end

  // Row nets: parallel contacts from driving columns and guess lines.
  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    logic [NUM_COLS-1:0]  colHits;
    logic [NUM_GUESS-1:0] guessHits;
    for (genvar c = 0; c < NUM_COLS; c++) begin : g_cin
      assign colHits[c] = colState[c] & COL_OUT_MASK[c*NUM_ROWS + r];
    end
    for (genvar g = 0; g < NUM_GUESS; g++) begin : g_gin
      assign guessHits[g] = guessIn[g] & GUESS_MASK[g*NUM_ROWS + r];
    end
    assign rowFire[r] = (|colHits) | (|guessHits);
  end

  // Both halves step from registered state: one edge is one switch turn.
  assign rowNext = rowState | rowFire;
  assign colNext = colState | colFire;

  assign netsChanged = strobes.advance &&
                       ((rowNext != rowState) || (colNext != colState));

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearNets) begin
      rowState <= '0;
      colState <= '0;
    end else if (strobes.advance) begin
      rowState <= rowNext;
      colState <= colNext;
    end
  end

endmodule

// File: rtl/elim_lattice_deadeq.sv
module elim_lattice_deadeq #(
  parameter int NUM_EQ   = 3,
  parameter int NUM_ROWS = 8,
  parameter logic [NUM_EQ*NUM_ROWS-1:0] EQ_MASK = '0
) (
  input  logic [NUM_ROWS-1:0] rowLive,
  output logic [NUM_EQ-1:0]   eqDead,
  output logic                inconsistent
);

  for (genvar e = 0; e < NUM_EQ; e++) begin : g_eq
    localparam logic [NUM_ROWS-1:0] MEMBERS = EQ_MASK[e*NUM_ROWS +: NUM_ROWS];
    assign eqDead[e] = &(rowLive | ~MEMBERS);
  end

  assign inconsistent = |eqDead;

endmodule

// File: rtl/elim_lattice.sv
module elim_lattice
  import elim_lattice_pkg::*;
#(
  parameter int NUM_EQ    = 3,
  parameter int NUM_ROWS  = 8,
  parameter int NUM_COLS  = 14,
  parameter int NUM_GUESS = 2,
  // Column c reads rows in slice c (series contacts).
  parameter logic [NUM_COLS*NUM_ROWS-1:0] COL_IN_MASK =
    112'h4004_8002_2001_A010_4008_1004_0803,
  // Column c drives rows in slice c (parallel contacts).
  parameter logic [NUM_COLS*NUM_ROWS-1:0] COL_OUT_MASK =
    112'h0440_0280_0120_10A0_0840_0410_0308,
  parameter logic [NUM_GUESS*NUM_ROWS-1:0] GUESS_MASK = 16'h1008,
  parameter logic [NUM_EQ*NUM_ROWS-1:0]    EQ_MASK    = 24'hE0_18_07
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clearIn,
  input  logic [NUM_GUESS-1:0] guessIn,
  output logic [NUM_ROWS-1:0]  rowLive,
  output logic [NUM_EQ-1:0]    eqDead,
  output logic                 inconsistent,
  output logic                 settled
);

  latticeStrobes_t strobes;
  logic            netsChanged;

  elim_lattice_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .clearIn     (clearIn),
    .netsChanged (netsChanged),
    .strobes     (strobes),
    .settled     (settled)
  );

  elim_lattice_datapath #(
    .NUM_ROWS     (NUM_ROWS),
    .NUM_COLS     (NUM_COLS),
    .NUM_GUESS    (NUM_GUESS),
    .COL_IN_MASK  (COL_IN_MASK),
    .COL_OUT_MASK (COL_OUT_MASK),
    .GUESS_MASK   (GUESS_MASK)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .guessIn     (guessIn),
    .rowState    (rowLive),
    .netsChanged (netsChanged)
  );

  elim_lattice_deadeq #(
    .NUM_EQ   (NUM_EQ),
    .NUM_ROWS (NUM_ROWS),
    .EQ_MASK  (EQ_MASK)
  ) dead_i (
    .rowLive      (rowLive),
    .eqDead       (eqDead),
    .inconsistent (inconsistent)
  );

endmodule

// File: rtl/elim_lattice_checker.sv
module elim_lattice_checker #(
  parameter int NUM_EQ    = 3,
  parameter int NUM_ROWS  = 8,
  parameter int NUM_COLS  = 14,
  parameter int NUM_GUESS = 2,
  parameter logic [NUM_GUESS*NUM_ROWS-1:0] GUESS_MASK = '0
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 clearIn,
  input logic [NUM_GUESS-1:0] guessIn,
  input logic [NUM_ROWS-1:0]  rowLive,
  input logic [NUM_EQ-1:0]    eqDead,
  input logic                 inconsistent,
  input logic                 settled
);

  localparam int LIMIT = NUM_ROWS + NUM_COLS + 1;
  localparam int CW    = $clog2(LIMIT + 2) + 1;

  logic [CW-1:0] sinceClear;

  always_ff @(posedge clk) begin
    if (!rstN || clearIn) begin
      sinceClear <= '0;
    end else if (sinceClear < CW'(LIMIT + 1)) begin
      sinceClear <= sinceClear + 1'b1;
    end
  end

  // R1
  assert_reset_dark_R1: assert property (@(posedge clk)
    !rstN |=> (rowLive == '0 && !settled && !inconsistent));

  // R2
  assert_clear_dark_R2: assert property (@(posedge clk) disable iff (!rstN)
    clearIn |=> (rowLive == '0 && !settled));

  // R3
  for (genvar g = 0; g < NUM_GUESS; g++) begin : g_guess
    localparam logic [NUM_ROWS-1:0] GM = GUESS_MASK[g*NUM_ROWS +: NUM_ROWS];
    assert_guess_powers_R3: assert property (@(posedge clk) disable iff (!rstN)
      (!clearIn && guessIn[g]) |=> ((rowLive & GM) == GM));
  end

  // R5
  assert_sticky_rows_R5: assert property (@(posedge clk) disable iff (!rstN)
    !clearIn |=> ((rowLive & $past(rowLive)) == $past(rowLive)));

  // R7
  assert_flag_has_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    inconsistent |-> (eqDead != '0));

  // R8
  assert_settled_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (settled && !clearIn) |=> ($stable(rowLive) && settled));

  // R9
  assert_converge_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sinceClear >= CW'(LIMIT)) |-> settled);

endmodule

bind elim_lattice elim_lattice_checker #(
  .NUM_EQ     (NUM_EQ),
  .NUM_ROWS   (NUM_ROWS),
  .NUM_COLS   (NUM_COLS),
  .NUM_GUESS  (NUM_GUESS),
  .GUESS_MASK (GUESS_MASK)
) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .clearIn      (clearIn),
  .guessIn      (guessIn),
  .rowLive      (rowLive),
  .eqDead       (eqDead),
  .inconsistent (inconsistent),
  .settled      (settled)
);

// File: tb/elim_lattice_tb_top.sv
module elim_lattice_tb_top;

  // Configuration A: default wiring. Configuration B: small wiring.
  localparam logic [111:0] A_IN  = 112'h4004_8002_2001_A010_4008_1004_0803;
  localparam logic [111:0] A_OUT = 112'h0440_0280_0120_10A0_0840_0410_0308;
  localparam logic [15:0]  A_GM  = 16'h1008;
  localparam logic [23:0]  A_EQ  = 24'hE0_18_07;
  localparam logic [5:0]   B_IN  = 6'b011_000;
  localparam logic [5:0]   B_OUT = 6'b100_001;
  localparam logic [2:0]   B_GM  = 3'b010;
  localparam logic [5:0]   B_EQ  = 6'b100_011;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clearIn = 1'b0;
  logic [1:0] guessA = '0;
  logic [0:0] guessB = '0;
  logic [7:0] rowA;
  logic [2:0] eqDeadA;
  logic inconA, setA;
  logic [2:0] rowB;
  logic [1:0] eqDeadB;
  logic inconB, setB;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  elim_lattice dut_i (
    .clk(clk), .rstN(rstN), .clearIn(clearIn), .guessIn(guessA),
    .rowLive(rowA), .eqDead(eqDeadA), .inconsistent(inconA), .settled(setA)
  );

  elim_lattice #(
    .NUM_EQ(2), .NUM_ROWS(3), .NUM_COLS(2), .NUM_GUESS(1),
    .COL_IN_MASK(B_IN), .COL_OUT_MASK(B_OUT), .GUESS_MASK(B_GM), .EQ_MASK(B_EQ)
  ) dut2_i (
    .clk(clk), .rstN(rstN), .clearIn(clearIn), .guessIn(guessB),
    .rowLive(rowB), .eqDead(eqDeadB), .inconsistent(inconB), .settled(setB)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Arithmetic propagation model, independent of the RTL structure.
  function automatic logic [15:0] modelRows(input logic [15:0] r, input logic [15:0] c,
      input logic [3:0] g, input int nR, input int nC, input int nG,
      input logic [255:0] outM, input logic [63:0] gM);
    logic [15:0] n = r;
    for (int i = 0; i < nR; i++) begin
      for (int k = 0; k < nC; k++) if (c[k] && outM[k*nR+i]) n[i] = 1'b1;
      for (int k = 0; k < nG; k++) if (g[k] && gM[k*nR+i]) n[i] = 1'b1;
    end
    return n;
  endfunction

  function automatic logic [15:0] modelCols(input logic [15:0] r, input logic [15:0] c,
      input int nR, input int nC, input logic [255:0] inM);
    logic [15:0] n = c;
    for (int k = 0; k < nC; k++) begin
      bit all = 1;
      for (int i = 0; i < nR; i++) if (inM[k*nR+i] && !r[i]) all = 0;
      if (all) n[k] = 1'b1;
    end
    return n;
  endfunction

  function automatic logic [15:0] modelDead(input logic [15:0] r, input int nR,
      input int nE, input logic [63:0] eqM);
    logic [15:0] d = '0;
    for (int e = 0; e < nE; e++) begin
      bit all = 1;
      for (int i = 0; i < nR; i++) if (eqM[e*nR+i] && !r[i]) all = 0;
      d[e] = all;
    end
    return d;
  endfunction

  // One trial: clear with the guess already present, then propagate.
  task automatic runTrial(input logic [1:0] gA, input logic gB);
    logic [15:0] mRowA = '0, mColA = '0, mRowB = '0, mColB = '0;
    logic [15:0] nR, nC;
    logic mSetA = 0, mSetB = 0;
    int firstIncon = -1;
    @(negedge clk);
    guessA = gA; guessB = gB; clearIn = 1'b1;
    @(negedge clk);
    // R2: guess present on the clear edge has no effect.
    check("R2 rowsA after clear", {8'h0, rowA}, 16'h0);
    check("R2 rowsB after clear", {13'h0, rowB}, 16'h0);
    check("R2 settled low after clear", {14'h0, setA, setB}, 16'h0);
    clearIn = 1'b0;
    for (int cyc = 1; cyc <= 26; cyc++) begin
      @(negedge clk);
      nR = modelRows(mRowA, mColA, {2'b0, gA}, 8, 14, 2, {144'h0, A_OUT}, {48'h0, A_GM});
      nC = modelCols(mRowA, mColA, 8, 14, {144'h0, A_IN});
      mSetA = (nR == mRowA) && (nC == mColA);
      mRowA = nR; mColA = nC;
      nR = modelRows(mRowB, mColB, {3'b0, gB}, 3, 2, 1, {250'h0, B_OUT}, {61'h0, B_GM});
      nC = modelCols(mRowB, mColB, 3, 2, {250'h0, B_IN});
      mSetB = (nR == mRowB) && (nC == mColB);
      mRowB = nR; mColB = nC;
      // R3 R4 R5: rows follow the propagation model edge by edge.
      check("R3/R4/R5 rowsA", {8'h0, rowA}, mRowA);
      check("R3/R4/R5 rowsB", {13'h0, rowB}, mRowB);
      check("R6 eqDeadA", {13'h0, eqDeadA}, modelDead(mRowA, 8, 3, {40'h0, A_EQ}));
      check("R6 eqDeadB", {14'h0, eqDeadB}, modelDead(mRowB, 3, 2, {58'h0, B_EQ}));
      check("R7 inconsistentA", {15'h0, inconA}, {15'h0, |modelDead(mRowA, 8, 3, {40'h0, A_EQ})});
      check("R7 inconsistentB", {15'h0, inconB}, {15'h0, |modelDead(mRowB, 3, 2, {58'h0, B_EQ})});
      check("R8 settledA", {15'h0, setA}, {15'h0, mSetA});
      check("R8 settledB", {15'h0, setB}, {15'h0, mSetB});
      if (inconA && firstIncon < 0) firstIncon = cyc;
      if (cyc == 23) check("R9 settledA within bound", {15'h0, setA}, 16'h1);
      if (cyc == 6)  check("R9 settledB within bound", {15'h0, setB}, 16'h1);
      if (cyc == 2 && !gB) check("R4 empty-series seed rowsB", {13'h0, rowB}, 16'h0001);
    end
    if (gA == 2'b01 || gA == 2'b10) begin
      check("R10 all rows on", {8'h0, rowA}, 16'h00FF);
      check("R10 inconsistent", {15'h0, inconA}, 16'h1);
      check("R10 first inconsistent edge", firstIncon[15:0], 16'd5);
    end
    if (gA == 2'b00) check("R10 no guess stays dark", {8'h0, rowA}, 16'h0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    guessA = 2'b11; guessB = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state with guesses asserted.
    check("R1 rowsA in reset", {8'h0, rowA}, 16'h0);
    check("R1 rowsB in reset", {13'h0, rowB}, 16'h0);
    check("R1 flags in reset", {12'h0, setA, inconA, setB, inconB}, 16'h0);
    check("R1 eqDeadA in reset", {13'h0, eqDeadA}, 16'h0);
    rstN = 1'b1;
    for (int gA = 0; gA < 4; gA++) begin
      for (int gB = 0; gB < 2; gB++) begin
        runTrial(gA[1:0], gB[0]);
      end
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule